// File: doc/BRIEF.md
# Skewed Hybrid Branch Direction Predictor

This block predicts whether a conditional branch is taken. It keeps four tables of 2-bit saturating counters. The first is a bimodal table indexed by the branch address alone. Two further predictor tables and a chooser table are indexed by different skewed mixes of the address and an internal global outcome history. The predictor tables vote by majority. For each branch, the chooser counter selects either that vote or the bimodal counter as the final direction.

A request carries the branch address. One cycle later the block returns the direction. Along with it come the four table indices, the four counter values read and the history snapshot used. The pipeline holds these and hands them back with the resolved outcome on the update port. The training logic then works only from those carried values and needs no second table read. Training is partial. Tables are written only where the agreement pattern and the correctness of the prediction call for it, which keeps aliasing pressure on the shared tables low.

Top module: `skew_bp_top`

## Requirements
- R1: After reset, `pred_valid` is 0 and the history is all zeros. Every bimodal and history-table counter holds 1 (weak not-taken). Every chooser counter holds 2 (weakly prefers the vote).
- R2: Let `a` be the XOR fold of `req_pc` bit 2 upward into IDX_W bits: result bit k is the XOR of the address bits at k+2, k+2+IDX_W, k+2+2*IDX_W and so on. Let `h` be the history. The indices are then: bimodal = `a`; first history table = `a ^ h`; second history table = `a ^ reverse(h)`; chooser = `a ^ rotl1(h)`, where rotl1 moves bit IDX_W-1 into bit 0.
- R3: `pred_valid` rises the cycle after `req_valid`. A counter predicts taken when its value is 2 or 3. The vote is the majority of the three predictor tables. `pred_taken` is the vote when the chooser counter is 2 or 3, and the bimodal prediction otherwise.
- R4: An update whose final direction was correct and whose three predictor tables agreed writes no table.
- R5: An update with a correct final direction but disagreeing predictor tables steps each predictor counter that was right one step toward the outcome. It leaves the wrong ones unchanged.
- R6: On a misprediction the chooser is trained first and the final direction is recomputed with the new chooser value. If the recomputed direction matches the outcome, only the predictor counters that were right are stepped toward the outcome.
- R7: On a misprediction whose recomputed direction is still wrong, all three predictor counters are stepped toward the outcome.
- R8: Whenever the chooser may be trained (every update except the R4 case), it moves up one step when the vote was right and bimodal wrong. It moves down one step when bimodal was right and the vote wrong. Otherwise it is unchanged.
- R9: Counters saturate: a step up from 3 stays 3, and a step down from 0 stays 0.
- R10: Each update shifts the outcome into history bit 0, with the older bits moving up by one. Without an update the history holds. `pred_ghr` shows the history used for that prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Prediction request |
| req_pc | input | PC_W-2 | Branch address, word bits upward |
| pred_valid | output | 1 | Prediction result valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_ghr | output | IDX_W | History used for this prediction |
| pred_idx_bim | output | IDX_W | Bimodal index |
| pred_idx_g0 | output | IDX_W | First history-table index |
| pred_idx_g1 | output | IDX_W | Second history-table index |
| pred_idx_meta | output | IDX_W | Chooser index |
| pred_ctr_bim | output | 2 | Bimodal counter read |
| pred_ctr_g0 | output | 2 | First history-table counter read |
| pred_ctr_g1 | output | 2 | Second history-table counter read |
| pred_ctr_meta | output | 2 | Chooser counter read |
| upd_valid | input | 1 | Resolved branch update |
| upd_taken | input | 1 | Actual outcome |
| upd_idx_bim | input | IDX_W | Carried bimodal index |
| upd_idx_g0 | input | IDX_W | Carried first history-table index |
| upd_idx_g1 | input | IDX_W | Carried second history-table index |
| upd_idx_meta | input | IDX_W | Carried chooser index |
| upd_ctr_bim | input | 2 | Carried bimodal counter |
| upd_ctr_g0 | input | 2 | Carried first history-table counter |
| upd_ctr_g1 | input | 2 | Carried second history-table counter |
| upd_ctr_meta | input | 2 | Carried chooser counter |

## Verification
The assertions assume that the update port carries back the indices and counter values of a real earlier prediction. Only then do the training decisions they check match the counters in the tables. The bench keeps to this by resolving each branch just after its prediction. It never overlaps a request and an update, and it copies the carried fields from the prediction it has just seen. A small set of recurring addresses with biased, partly random outcomes drives the counters into saturation and pushes the chooser both ways. This covers every agreement and correctness case of the training rules.

// File: rtl/skew_bp_pkg.sv
package skew_bp_pkg;
    typedef logic [1:0] ctr_t;

    localparam int NTAB    = 4;
    localparam int TB_BIM  = 0;
    localparam int TB_G0   = 1;
    localparam int TB_G1   = 2;
    localparam int TB_META = 3;

    // one saturating step toward the requested direction
    function automatic ctr_t ctr_step(ctr_t c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        else    return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic maj3(logic x, logic y, logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic logic final_dir(ctr_t b, ctr_t g0, ctr_t g1, ctr_t m);
        return m[1] ? maj3(b[1], g0[1], g1[1]) : b[1];
    endfunction

    typedef struct packed {
        logic [NTAB-1:0] we;
        ctr_t [NTAB-1:0] val;
    } wr_t;
endpackage

// File: rtl/skew_bp_hash.sv
module skew_bp_hash
    import skew_bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 8
) (
    input  logic [PC_W-1:2]              pc_i,
    input  logic [IDX_W-1:0]             hist_i,
    output logic [NTAB-1:0][IDX_W-1:0]   idx_o
);
    localparam int ABITS = PC_W - 2;

    logic [IDX_W-1:0] fold;
    logic [IDX_W-1:0] hrev;
    logic [IDX_W-1:0] hrot;

    always_comb begin
        fold = '0;
        for (int i = 0; i < ABITS; i++) begin
            fold[i % IDX_W] = fold[i % IDX_W] ^ pc_i[i+2];
        end
    end

    generate
        for (genvar k = 0; k < IDX_W; k++) begin : g_rev
            assign hrev[k] = hist_i[IDX_W-1-k];
        end
    endgenerate

    assign hrot = {hist_i[IDX_W-2:0], hist_i[IDX_W-1]};

    always_comb begin
        idx_o          = '0;
        idx_o[TB_BIM]  = fold;
        idx_o[TB_G0]   = fold ^ hist_i;
        idx_o[TB_G1]   = fold ^ hrev;
        idx_o[TB_META] = fold ^ hrot;
    end
endmodule

// File: rtl/skew_bp_table.sv
module skew_bp_table
    import skew_bp_pkg::*;
#(
    parameter int   ENTRIES = 256,
    parameter int   IDX_W   = 8,
    parameter ctr_t RST_VAL = 2'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_t             wr_ctr
);
    ctr_t ctr_q [ENTRIES];
    ctr_t ctr_d [ENTRIES];

    always_comb begin
        ctr_d = ctr_q;
        if (we) ctr_d[wr_idx] = wr_ctr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= RST_VAL;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/skew_bp_train.sv
module skew_bp_train
    import skew_bp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic taken_i,
    input  ctr_t bim_i,
    input  ctr_t g0_i,
    input  ctr_t g1_i,
    input  ctr_t meta_i,
    output wr_t  wr_o
);
    logic pb, p0, p1, vote, fin, fin2;
    logic agree, bim_ok, vote_ok;
    ctr_t meta_new;

    always_comb begin
        pb      = bim_i[1];
        p0      = g0_i[1];
        p1      = g1_i[1];
        vote    = maj3(pb, p0, p1);
        fin     = final_dir(bim_i, g0_i, g1_i, meta_i);
        agree   = (pb == p0) && (p0 == p1);
        bim_ok  = (pb == taken_i);
        vote_ok = (vote == taken_i);

        meta_new = meta_i;
        if (vote_ok && !bim_ok)      meta_new = ctr_step(meta_i, 1'b1);
        else if (bim_ok && !vote_ok) meta_new = ctr_step(meta_i, 1'b0);
        fin2 = meta_new[1] ? vote : pb;

        wr_o               = '0;
        wr_o.val[TB_BIM]   = ctr_step(bim_i, taken_i);
        wr_o.val[TB_G0]    = ctr_step(g0_i, taken_i);
        wr_o.val[TB_G1]    = ctr_step(g1_i, taken_i);
        wr_o.val[TB_META]  = meta_new;

        if (valid_i && !(fin == taken_i && agree)) begin
            wr_o.we[TB_META] = (vote_ok != bim_ok);
            if (fin == taken_i || fin2 == taken_i) begin
                wr_o.we[TB_BIM] = bim_ok;
                wr_o.we[TB_G0]  = (p0 == taken_i);
                wr_o.we[TB_G1]  = (p1 == taken_i);
            end else begin
                wr_o.we[TB_BIM] = 1'b1;
                wr_o.we[TB_G0]  = 1'b1;
                wr_o.we[TB_G1]  = 1'b1;
            end
        end
    end

    AST_AGREE_CORRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && bim_i[1] == taken_i && g0_i[1] == taken_i && g1_i[1] == taken_i
        |-> wr_o.we == '0); // R4

    AST_META_EQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (maj3(bim_i[1], g0_i[1], g1_i[1]) == bim_i[1])
        |-> !wr_o.we[TB_META]); // R8

    AST_BOTH_WRONG_TRAIN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && bim_i[1] != taken_i && maj3(bim_i[1], g0_i[1], g1_i[1]) != taken_i
        |-> wr_o.we[TB_BIM] && wr_o.we[TB_G0] && wr_o.we[TB_G1]); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && wr_o.we[TB_BIM]
        |-> (taken_i ? (wr_o.val[TB_BIM] >= bim_i) : (wr_o.val[TB_BIM] <= bim_i))); // R9

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> wr_o.we == '0); // R4
endmodule

// File: rtl/skew_bp_top.sv
module skew_bp_top
    import skew_bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PC_W-1:2]  req_pc,
    output logic             pred_valid,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_ghr,
    output logic [IDX_W-1:0] pred_idx_bim,
    output logic [IDX_W-1:0] pred_idx_g0,
    output logic [IDX_W-1:0] pred_idx_g1,
    output logic [IDX_W-1:0] pred_idx_meta,
    output logic [1:0]       pred_ctr_bim,
    output logic [1:0]       pred_ctr_g0,
    output logic [1:0]       pred_ctr_g1,
    output logic [1:0]       pred_ctr_meta,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [IDX_W-1:0] upd_idx_bim,
    input  logic [IDX_W-1:0] upd_idx_g0,
    input  logic [IDX_W-1:0] upd_idx_g1,
    input  logic [IDX_W-1:0] upd_idx_meta,
    input  logic [1:0]       upd_ctr_bim,
    input  logic [1:0]       upd_ctr_g0,
    input  logic [1:0]       upd_ctr_g1,
    input  logic [1:0]       upd_ctr_meta
);
    typedef struct packed {
        logic                       vld;
        logic                       dir;
        logic [IDX_W-1:0]           ghr;
        logic [IDX_W-1:0]           pghr;
        logic [NTAB-1:0][IDX_W-1:0] idx;
        ctr_t [NTAB-1:0]            ctr;
    } st_t;

    st_t st_q, st_d;

    logic [NTAB-1:0][IDX_W-1:0] rd_idx;
    ctr_t                       rd_ctr [NTAB];
    logic [IDX_W-1:0]           wr_idx [NTAB];
    wr_t                        wr;

    skew_bp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash (
        .pc_i   (req_pc),
        .hist_i (st_q.ghr),
        .idx_o  (rd_idx)
    );

    assign wr_idx[TB_BIM]  = upd_idx_bim;
    assign wr_idx[TB_G0]   = upd_idx_g0;
    assign wr_idx[TB_G1]   = upd_idx_g1;
    assign wr_idx[TB_META] = upd_idx_meta;

    generate
        for (genvar t = 0; t < NTAB; t++) begin : g_tab
            localparam ctr_t RV = (t == TB_META) ? 2'd2 : 2'd1;
            skew_bp_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .RST_VAL(RV)) u_tab (
                .clk    (clk),
                .rst_n  (rst_n),
                .rd_idx (rd_idx[t]),
                .rd_ctr (rd_ctr[t]),
                .we     (wr.we[t]),
                .wr_idx (wr_idx[t]),
                .wr_ctr (wr.val[t])
            );
        end
    endgenerate

    skew_bp_train u_train (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (upd_valid),
        .taken_i (upd_taken),
        .bim_i   (upd_ctr_bim),
        .g0_i    (upd_ctr_g0),
        .g1_i    (upd_ctr_g1),
        .meta_i  (upd_ctr_meta),
        .wr_o    (wr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.dir  = final_dir(rd_ctr[TB_BIM], rd_ctr[TB_G0], rd_ctr[TB_G1], rd_ctr[TB_META]);
            st_d.pghr = st_q.ghr;
            st_d.idx  = rd_idx;
            for (int t = 0; t < NTAB; t++) st_d.ctr[t] = rd_ctr[t];
        end
        if (upd_valid) st_d.ghr = {st_q.ghr[IDX_W-2:0], upd_taken};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_valid    = st_q.vld;
    assign pred_taken    = st_q.dir;
    assign pred_ghr      = st_q.pghr;
    assign pred_idx_bim  = st_q.idx[TB_BIM];
    assign pred_idx_g0   = st_q.idx[TB_G0];
    assign pred_idx_g1   = st_q.idx[TB_G1];
    assign pred_idx_meta = st_q.idx[TB_META];
    assign pred_ctr_bim  = st_q.ctr[TB_BIM];
    assign pred_ctr_g0   = st_q.ctr[TB_G0];
    assign pred_ctr_g1   = st_q.ctr[TB_G1];
    assign pred_ctr_meta = st_q.ctr[TB_META];

    AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> st_q.ghr[0] == $past(upd_taken)); // R10

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(st_q.ghr)); // R10

    AST_PRED_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pred_valid); // R3
endmodule

// File: tb/skew_bp_top_bench.sv
module skew_bp_top_bench;
    localparam int PC_W = 32;
    localparam int ENT  = 256;
    localparam int IW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [PC_W-1:2] req_pc = '0;
    logic pred_valid, pred_taken;
    logic [IW-1:0] pred_ghr, pred_idx_bim, pred_idx_g0, pred_idx_g1, pred_idx_meta;
    logic [1:0] pred_ctr_bim, pred_ctr_g0, pred_ctr_g1, pred_ctr_meta;
    logic upd_valid = 1'b0, upd_taken = 1'b0;
    logic [IW-1:0] upd_idx_bim = '0, upd_idx_g0 = '0, upd_idx_g1 = '0, upd_idx_meta = '0;
    logic [1:0] upd_ctr_bim = '0, upd_ctr_g0 = '0, upd_ctr_g1 = '0, upd_ctr_meta = '0;

    always #10 clk = ~clk;

    skew_bp_top #(.PC_W(PC_W), .ENTRIES(ENT)) u_skew_bp_top (.*);

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int idx [4];
        int ctr [4];
        int dir;
        int ghr;
        int tag;
    } exp_t;

    exp_t sb [$];
    exp_t last;

    int tb_ctr [4][ENT];
    int ghr_m = 0;
    int next_tag = 1;

    function automatic string tname(int t);
        case (t)
            1: return "R1";  4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  9: return "R9";  default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int step(int c, int up);
        if (up != 0) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // R2 index spec
    function automatic void calc_idx(logic [PC_W-1:2] pc, int h, output int ix [4]);
        int a = 0, rev = 0, rot;
        for (int i = 0; i < PC_W - 2; i++) if (pc[i+2]) a = a ^ (1 << (i % IW));
        for (int k = 0; k < IW; k++) if (h[k]) rev = rev | (1 << (IW - 1 - k));
        rot = ((h << 1) | (h >> (IW - 1))) & (ENT - 1);
        ix[0] = a; ix[1] = a ^ h; ix[2] = a ^ rev; ix[3] = a ^ rot;
    endfunction

    task automatic predict(logic [PC_W-1:2] pc);
        exp_t e;
        int b, v;
        calc_idx(pc, ghr_m, e.idx);
        for (int t = 0; t < 4; t++) e.ctr[t] = tb_ctr[t][e.idx[t]];
        b = e.ctr[0] >> 1;
        v = ((e.ctr[0] >> 1) + (e.ctr[1] >> 1) + (e.ctr[2] >> 1)) >= 2 ? 1 : 0;
        e.dir = (e.ctr[3] >= 2) ? v : b;
        e.ghr = ghr_m;
        e.tag = next_tag;
        sb.push_back(e);
        last = e;
        @(negedge clk);
        req_pc = pc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic update(int tk);
        int c [4];
        int pb, p0, p1, v, fin, fin2, nm, cls, sat;
        int we [4];
        c = last.ctr;
        pb = c[0] >> 1; p0 = c[1] >> 1; p1 = c[2] >> 1;
        v = (pb + p0 + p1) >= 2 ? 1 : 0;
        fin = (c[3] >= 2) ? v : pb;
        we = '{0, 0, 0, 0};
        nm = c[3];
        if (v == tk && pb != tk) nm = step(c[3], 1);
        else if (pb == tk && v != tk) nm = step(c[3], 0);
        fin2 = (nm >= 2) ? v : pb;
        if (fin == tk && pb == p0 && p0 == p1) cls = 4;          // R4
        else begin
            we[3] = (nm != c[3]) ? 1 : 0;
            if (fin == tk || fin2 == tk) begin
                cls = (fin == tk) ? 5 : 6;                       // R5 / R6
                we[0] = (pb == tk); we[1] = (p0 == tk); we[2] = (p1 == tk);
            end else begin
                cls = 7;                                         // R7
                we = '{1, 1, 1, we[3]};
            end
        end
        sat = 0;
        for (int t = 0; t < 3; t++)
            if (we[t] != 0 && ((tk != 0 && c[t] == 3) || (tk == 0 && c[t] == 0))) sat = 1;
        if (sat != 0) cls = 9;                                   // R9
        else if (cls == 5 && we[3] != 0) cls = 8;                // R8
        for (int t = 0; t < 3; t++) if (we[t] != 0) tb_ctr[t][last.idx[t]] = step(c[t], tk);
        if (we[3] != 0) tb_ctr[3][last.idx[3]] = nm;
        ghr_m = ((ghr_m << 1) | tk) & (ENT - 1);                 // R10
        next_tag = cls;
        @(negedge clk);
        upd_valid = 1'b1; upd_taken = tk[0];
        upd_idx_bim = last.idx[0][IW-1:0]; upd_idx_g0 = last.idx[1][IW-1:0];
        upd_idx_g1 = last.idx[2][IW-1:0]; upd_idx_meta = last.idx[3][IW-1:0];
        upd_ctr_bim = last.ctr[0][1:0]; upd_ctr_g0 = last.ctr[1][1:0];
        upd_ctr_g1 = last.ctr[2][1:0]; upd_ctr_meta = last.ctr[3][1:0];
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // monitor: pops one expected item per valid prediction
    always @(negedge clk) begin
        if (rst_n && pred_valid) begin
            exp_t e;
            if (sb.size() == 0) chk("R3", 1, 0);
            else begin
                e = sb.pop_front();
                chk("R2", int'(pred_idx_bim),  e.idx[0]);
                chk("R2", int'(pred_idx_g0),   e.idx[1]);
                chk("R2", int'(pred_idx_g1),   e.idx[2]);
                chk("R2", int'(pred_idx_meta), e.idx[3]);
                chk(tname(e.tag), int'(pred_ctr_bim),  e.ctr[0]);
                chk(tname(e.tag), int'(pred_ctr_g0),   e.ctr[1]);
                chk(tname(e.tag), int'(pred_ctr_g1),   e.ctr[2]);
                chk(tname(e.tag), int'(pred_ctr_meta), e.ctr[3]);
                chk("R3", int'(pred_taken), e.dir);
                chk("R10", int'(pred_ghr), e.ghr);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [PC_W-1:2] pcs [4];
        for (int t = 0; t < 3; t++) for (int i = 0; i < ENT; i++) tb_ctr[t][i] = 1;
        for (int i = 0; i < ENT; i++) tb_ctr[3][i] = 2;
        pcs[0] = 30'h0000_0040; pcs[1] = 30'h0012_3457;
        pcs[2] = 30'h2A00_0113; pcs[3] = 30'h0000_0381;
        repeat (3) @(negedge clk);
        chk("R1", int'(pred_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(pred_valid), 0);
        // R1 defaults, then R4 quiet update
        predict(pcs[0]); update(0);
        predict(pcs[0]);
        // R7 both wrong
        update(1);
        // R10: no update leaves history, repeated request sees same ghr
        predict(pcs[1]); predict(pcs[1]);
        // R9 saturation: long taken run on one address
        for (int i = 0; i < 12; i++) begin predict(pcs[2]); update(1); end
        for (int i = 0; i < 12; i++) begin predict(pcs[2]); update(0); end
        // mixed biased traffic covering R5, R6, R8
        for (int i = 0; i < 500; i++) begin
            int s = $urandom_range(0, 3);
            int tk;
            case (s)
                0: tk = ($urandom_range(0, 9) < 8) ? 1 : 0;
                1: tk = ($urandom_range(0, 9) < 2) ? 1 : 0;
                2: tk = i % 2;
                default: tk = $urandom_range(0, 1);
            endcase
            predict(pcs[s]);
            update(tk);
        end
        predict(pcs[3]);
        @(negedge clk);
        chk("R3", sb.size(), 0);
        finish_run();
    end
endmodule